// File: doc/BRIEF.md
# Per-Rail Power-Good Qualifier

This block decides whether one regulator rail contributes "good" to a shared power-good signal. It takes the rail's lifecycle phase, digital copies of its undervoltage, overvoltage and current-limit comparators, and a few configuration bits. From these it produces one registered good bit, which is combined with the good bits of other rails outside this block.

The phase decides most of the result. A rail that is off, or winding down, never pulls the shared signal low. A rail that is starting up, ramping, or changing its set point always pulls it low. A rail that was shut down by a protection event pulls it low while its interrupt stays unserviced.

Only a settled rail is judged by its comparators, through an asymmetric debounce. A short cycle count must pass before the rail is declared bad, and a separately selectable, longer count before it is declared good again. A one-cycle fault pulse marks every falling edge of the good bit.

Top module: `pg_rail_qualifier`

## Requirements
- R1: While `rst_n` is low, `rail_good` and `fault_pulse` are 0.
- R2: When `mon_sel` is 2'b00 (no monitoring), `rail_good` is 1 after the next clock edge, whatever the phase and comparator inputs.
- R3: With `rail_state` 0 (off), 6 (shutdown delay) or 7 (ramp-down), `rail_good` is 1 after the next clock edge.
- R4: With `rail_state` 1 (start-up delay), 2 (soft start), 3 (ramp-up), 5 (set-point change ramp) or any undefined code 9 to 15, `rail_good` is 0 after the next clock edge. The debounce restarts from the bad state, with its count cleared.
- R5: With `rail_state` 8 (protection shutdown), `rail_good` is 0 while `irq_pending` is 1 and 1 while it is 0.
- R6: With `rail_state` 4 (settled), a bad rail becomes good only after VAL consecutive edges with no invalid condition. VAL is `VAL_SLOW_CYC` when `slow_valid` is 1 and `VAL_FAST_CYC` otherwise. A shorter valid run leaves it bad.
- R7: The invalid condition is met by `uv_flag` in every mode. It is met by `ov_flag` only when `win_both` is 1. It is met by `ilim_flag` only when `mon_sel` is 2'b10 or 2'b11; with 2'b01 (voltage only), current limit has no effect.
- R8: A settled good rail becomes bad only after `INV_CYC` consecutive edges with the invalid condition. A shorter invalid run leaves it good.
- R9: `fault_pulse` is 1 for exactly one cycle, in the cycle in which `rail_good` has just fallen from 1 to 0. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_state | input | 4 | Lifecycle phase code of the rail |
| mon_sel | input | 2 | Monitoring select: 00 none, 01 voltage, 10/11 voltage and current |
| win_both | input | 1 | 1: overvoltage counts as invalid as well as undervoltage |
| slow_valid | input | 1 | Selects the long bad-to-good filter time |
| irq_pending | input | 1 | Protection interrupt of the rail not yet serviced |
| uv_flag | input | 1 | Undervoltage comparator, synchronous |
| ov_flag | input | 1 | Overvoltage comparator, synchronous |
| ilim_flag | input | 1 | Current-limit comparator, synchronous |
| rail_good | output | 1 | Registered power-good contribution |
| fault_pulse | output | 1 | One-cycle pulse on a falling `rail_good` |

## Verification
The bench runs the settled rail under every combination of monitoring mode, window mode and valid-delay select. In each combination, it holds each comparator flag for one cycle less than the invalid count and then for the full count. The first run must not change the output. The second shows whether that flag is honoured in that mode: a fall, with its fault pulse, or no change.

Valid runs one cycle short of the selected count, cut off by a one-cycle invalid glitch, tell the two valid delays apart from each other and from the invalid delay. A separate sweep steps a good rail into every phase code, with the interrupt both set and clear. This separates the phases that force active, the phases that force inactive, and the phase that depends on the interrupt.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [3:0] {
        RS_OFF       = 4'd0,
        RS_START_DLY = 4'd1,
        RS_SOFT      = 4'd2,
        RS_RAMP_UP   = 4'd3,
        RS_SETTLED   = 4'd4,
        RS_VCHANGE   = 4'd5,
        RS_STOP_DLY  = 4'd6,
        RS_RAMP_DN   = 4'd7,
        RS_PROT_OFF  = 4'd8
    } rail_phase_e;

    typedef enum logic [1:0] {
        MON_NONE     = 2'b00,
        MON_VOLT     = 2'b01,
        MON_VCUR     = 2'b10,
        MON_VCUR_ALT = 2'b11
    } mon_mode_e;

    function automatic logic current_watched(input logic [1:0] sel);
        return (sel == MON_VCUR) || (sel == MON_VCUR_ALT);
    endfunction

    typedef struct packed {
        logic good;
        logic fault;
    } pg_out_t;

endpackage

// File: rtl/pg_fault_classify.sv
module pg_fault_classify
    import pg_pkg::*;
(
    input  logic       uv,
    input  logic       ov,
    input  logic       ilim,
    input  logic       win_both,
    input  logic [1:0] mon_sel,
    output logic       invalid
);

    logic volt_bad;
    logic cur_bad;

    always_comb begin
        volt_bad = uv | (win_both & ov);
        cur_bad  = current_watched(mon_sel) & ilim;
        invalid  = volt_bad | cur_bad;
    end

endmodule

// File: rtl/pg_debounce.sv
module pg_debounce #(
    parameter int INV_CYC      = 350,
    parameter int VAL_FAST_CYC = 550,
    parameter int VAL_SLOW_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic invalid,
    input  logic slow_sel,
    output logic ok_d
);

    localparam int MAX_A = (INV_CYC > VAL_FAST_CYC) ? INV_CYC : VAL_FAST_CYC;
    localparam int MAX_C = (MAX_A > VAL_SLOW_CYC) ? MAX_A : VAL_SLOW_CYC;
    localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C + 1) : 1;
    localparam logic [CW-1:0] INV_LIM  = CW'(INV_CYC - 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(VAL_FAST_CYC - 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(VAL_SLOW_CYC - 1);
    localparam logic [CW-1:0] TOP_LIM  = CW'(MAX_C - 1);

    typedef struct packed {
        logic          ok;
        logic [CW-1:0] cnt;
    } dbn_t;

    dbn_t          st_d;
    dbn_t          st_q;
    logic [CW-1:0] lim;
    logic          disagree;

    always_comb begin
        st_d     = st_q;
        lim      = st_q.ok ? INV_LIM : (slow_sel ? SLOW_LIM : FAST_LIM);
        disagree = (st_q.ok == invalid);
        if (!run) begin
            st_d.ok  = 1'b0;
            st_d.cnt = '0;
        end else if (disagree) begin
            if (st_q.cnt >= lim) begin
                st_d.ok  = ~st_q.ok;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
        ok_d = st_d.ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ok: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R6 / R8: the run counter never passes the longest filter limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP_LIM);

    // R8: a good filter with a clean input stays good
    a_r8_clean_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.ok && !invalid) |=> st_q.ok);

    // R4: leaving the settled phase clears the filter
    a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!st_q.ok && st_q.cnt == '0));

endmodule

// File: rtl/pg_phase_gate.sv
module pg_phase_gate
    import pg_pkg::*;
(
    input  logic [3:0] rail_state,
    input  logic [1:0] mon_sel,
    input  logic       irq_pending,
    input  logic       filt_ok,
    output logic       run,
    output logic       good_d
);

    logic phase_good;

    always_comb begin
        run = (rail_state == RS_SETTLED);
        case (rail_state)
            RS_OFF, RS_STOP_DLY, RS_RAMP_DN: phase_good = 1'b1;
            RS_SETTLED:                      phase_good = filt_ok;
            RS_PROT_OFF:                     phase_good = ~irq_pending;
            default:                         phase_good = 1'b0;
        endcase
        good_d = (mon_sel == MON_NONE) | phase_good;
    end

endmodule

// File: rtl/pg_rail_qualifier.sv
module pg_rail_qualifier
    import pg_pkg::*;
#(
    parameter int INV_CYC      = 350,
    parameter int VAL_FAST_CYC = 550,
    parameter int VAL_SLOW_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rail_state,
    input  logic [1:0] mon_sel,
    input  logic       win_both,
    input  logic       slow_valid,
    input  logic       irq_pending,
    input  logic       uv_flag,
    input  logic       ov_flag,
    input  logic       ilim_flag,
    output logic       rail_good,
    output logic       fault_pulse
);

    logic    invalid;
    logic    run;
    logic    filt_ok;
    logic    good_d;
    pg_out_t out_d;
    pg_out_t out_q;

    pg_fault_classify u_classify (
        .uv       (uv_flag),
        .ov       (ov_flag),
        .ilim     (ilim_flag),
        .win_both (win_both),
        .mon_sel  (mon_sel),
        .invalid  (invalid)
    );

    pg_debounce #(
        .INV_CYC      (INV_CYC),
        .VAL_FAST_CYC (VAL_FAST_CYC),
        .VAL_SLOW_CYC (VAL_SLOW_CYC)
    ) u_debounce (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .invalid  (invalid),
        .slow_sel (slow_valid),
        .ok_d     (filt_ok)
    );

    pg_phase_gate u_gate (
        .rail_state  (rail_state),
        .mon_sel     (mon_sel),
        .irq_pending (irq_pending),
        .filt_ok     (filt_ok),
        .run         (run),
        .good_d      (good_d)
    );

    always_comb begin
        out_d.good  = good_d;
        out_d.fault = out_q.good & ~good_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{good: 1'b0, fault: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign rail_good   = out_q.good;
    assign fault_pulse = out_q.fault;

    a_r2_none_forces_good: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sel == 2'b00) |=> rail_good);

    a_r3_quiet_phase_good: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_state == 4'd0 || rail_state == 4'd6 || rail_state == 4'd7) |=> rail_good);

    a_r4_ramp_phase_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sel != 2'b00 && (rail_state == 4'd1 || rail_state == 4'd2 ||
         rail_state == 4'd3 || rail_state == 4'd5 || rail_state > 4'd8)) |=> !rail_good);

    a_r5_prot_pending_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sel != 2'b00 && rail_state == 4'd8 && irq_pending) |=> !rail_good);

    a_r7_ignored_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_state == 4'd4 && rail_good && !uv_flag && !(win_both && ov_flag) &&
         !((mon_sel == 2'b10 || mon_sel == 2'b11) && ilim_flag)) |=> rail_good);

    a_r9_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> !fault_pulse);

    a_r9_fault_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_good) |-> fault_pulse);

    a_r9_fault_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> (!rail_good && $past(rail_good)));

endmodule

// File: tb/pg_rail_qualifier_tb.sv
module pg_rail_qualifier_tb_top;

    localparam int INV = 3;
    localparam int VF  = 4;
    localparam int VS  = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rail_state = 4'd0;
    logic [1:0] mon_sel = 2'b01;
    logic       win_both = 1'b0;
    logic       slow_valid = 1'b0;
    logic       irq_pending = 1'b0;
    logic       uv_flag = 1'b0;
    logic       ov_flag = 1'b0;
    logic       ilim_flag = 1'b0;
    logic       rail_good;
    logic       fault_pulse;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pg_rail_qualifier #(
        .INV_CYC      (INV),
        .VAL_FAST_CYC (VF),
        .VAL_SLOW_CYC (VS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rail_state  (rail_state),
        .mon_sel     (mon_sel),
        .win_both    (win_both),
        .slow_valid  (slow_valid),
        .irq_pending (irq_pending),
        .uv_flag     (uv_flag),
        .ov_flag     (ov_flag),
        .ilim_flag   (ilim_flag),
        .rail_good   (rail_good),
        .fault_pulse (fault_pulse)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_flags(input logic u, input logic o, input logic l);
        uv_flag = u;
        ov_flag = o;
        ilim_flag = l;
    endtask

    // bring a rail from ramp-up to a settled good state
    task automatic settle(input int v);
        set_flags(1'b0, 1'b0, 1'b0);
        rail_state = 4'd3;
        step(1);
        chk("R4 ramp-up bad", rail_good, 1'b0);
        rail_state = 4'd4;
        step(v - 1);
        chk("R6 valid short of delay", rail_good, 1'b0);
        step(1);
        chk("R6 valid after delay", rail_good, 1'b1);
    endtask

    task automatic flag_case(input int which, input logic expect_fall, input int v);
        logic u, o, l;
        u = (which == 0);
        o = (which == 1);
        l = (which == 2);
        set_flags(u, o, l);
        step(INV - 1);
        set_flags(1'b0, 1'b0, 1'b0);
        chk("R8 invalid glitch ignored", rail_good, 1'b1);
        step(1);
        chk("R8 good after glitch", rail_good, 1'b1);
        set_flags(u, o, l);
        step(INV);
        chk("R7 flag honoured per mode", rail_good, !expect_fall);
        chk("R9 fault at fall", fault_pulse, expect_fall);
        step(1);
        chk("R9 fault one cycle", fault_pulse, 1'b0);
        set_flags(1'b0, 1'b0, 1'b0);
        if (expect_fall) begin
            step(v - 1);
            chk("R6 recovery short", rail_good, 1'b0);
            set_flags(u, o, l);
            step(1);
            set_flags(1'b0, 1'b0, 1'b0);
            chk("R6 valid run broken", rail_good, 1'b0);
            step(v - 1);
            chk("R6 restarted run short", rail_good, 1'b0);
            step(1);
            chk("R6 recovered", rail_good, 1'b1);
        end
    endtask

    initial begin
        step(3);
        chk("R1 good in reset", rail_good, 1'b0);
        chk("R1 fault in reset", fault_pulse, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R3 off phase good", rail_good, 1'b1);

        for (int s = 1; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    int v;
                    mon_sel    = 2'(s);
                    win_both   = 1'(w);
                    slow_valid = 1'(sl);
                    v = (sl != 0) ? VS : VF;
                    settle(v);
                    flag_case(0, 1'b1, v);
                    flag_case(1, (w != 0), v);
                    flag_case(2, (s >= 2), v);
                end
            end
        end

        // phase sweep from a good settled rail
        mon_sel = 2'b01;
        win_both = 1'b1;
        slow_valid = 1'b0;
        for (int st = 0; st < 16; st++) begin
            for (int q = 0; q < 2; q++) begin
                logic exp_g;
                settle(VF);
                irq_pending = 1'(q);
                rail_state  = 4'(st);
                case (st)
                    0, 6, 7: exp_g = 1'b1;
                    4:       exp_g = 1'b1;
                    8:       exp_g = (q == 0);
                    default: exp_g = 1'b0;
                endcase
                step(1);
                if (st == 8) chk("R5 protection phase", rail_good, exp_g);
                else if (exp_g) chk("R3 forced-good phase", rail_good, exp_g);
                else chk("R4 forced-bad phase", rail_good, exp_g);
                chk("R9 fault on phase fall", fault_pulse, !exp_g);
                irq_pending = 1'b0;
            end
        end

        // no monitoring: every phase and flag is overridden
        mon_sel = 2'b00;
        irq_pending = 1'b1;
        set_flags(1'b1, 1'b1, 1'b1);
        for (int st = 1; st < 16; st++) begin
            rail_state = 4'(st);
            step(1);
            chk("R2 no-monitor forced good", rail_good, 1'b1);
            chk("R9 no fault when good", fault_pulse, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule